// File: doc/BRIEF.md
# CPU Core Debug Control Unit

This block lets a debug host control a CPU core's execution through a small set of registers. The host writes command bits into a control register to halt the core, let it run again, reset it, step it by one instruction, or flush its instruction cache. The block drives the core's stop, reset and instruction-cache flush lines from those commands.

The host can also read two things back: a status word that shows whether the core is fully stopped, still draining toward a stop, or terminated, and the core's next instruction address. The core reports an in-flight flag, a terminated flag and a one-cycle pulse for each completed instruction. A single-step releases a halted core until the next completion pulse, then halts it again.

Host accesses use a simple request interface. A write takes effect at the clock edge where the request is sampled. A read is answered one cycle later with a registered acknowledge and data.

Top module: `dbg_core_ctrl`

## Requirements
- R1: While reset is active and on the first cycle after it, `core_stop`, `core_rst`, `icache_flush` and `host_ack` are all low (the default `RESET_HALTED` is 0).
- R2: The control register is at address 0. Bit 0 is stop, bit 1 is reset, bit 2 is icache-clear, bit 3 is step and bit 4 is start. Writing 1 to the stop bit raises `core_stop` from the cycle after the write. `core_stop` stays high until a start command is written.
- R3: Writing 1 to the start bit lowers `core_stop` from the cycle after the write and cancels any step in progress. If stop and start are written together, stop wins and the core stays halted.
- R4: Writing 1 to the reset bit raises `core_rst` for exactly one cycle, the cycle after the write. The halt state is not changed.
- R5: Writing 1 to the icache-clear bit raises `icache_flush` for exactly one cycle, the cycle after the write.
- R6: A step command written while the core is halted lowers `core_stop` from the next cycle. `core_stop` rises again in the cycle after the first `core_instr_done` pulse.
- R7: A step command written while the core is running has no effect: a later stop command halts the core at once. A `core_instr_done` pulse that arrives while no step is in progress does not change `core_stop`.
- R8: Every read is answered by `host_ack` high for one cycle, the cycle after the request. Reading address 1 returns the status word:
  - bit 0 is stopped (`core_stop` high and `core_busy` low);
  - bit 1 is stop-pending (`core_stop` high and `core_busy` high);
  - bit 2 is `core_terminated`;
  - all other bits are 0.
- R9: Reading address 2 returns `core_nia` as sampled at the request edge. Reading address 0 or 3 returns 0.
- R10: Writes to any address other than 0 have no effect on `core_stop`, `core_rst` or `icache_flush`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register address |
| host_wdata | input | 5 | Control command bits |
| host_ack | output | 1 | Read/write acknowledge, one cycle after request |
| host_rdata | output | DATA_W (64) | Read data, valid with `host_ack` |
| core_nia | input | NIA_W (64) | Core's next instruction address |
| core_busy | input | 1 | Core has an instruction in flight |
| core_terminated | input | 1 | Core has terminated |
| core_instr_done | input | 1 | One-cycle pulse per completed instruction |
| core_stop | output | 1 | Hold the core |
| core_rst | output | 1 | One-cycle core reset pulse |
| icache_flush | output | 1 | One-cycle instruction-cache clear pulse |

## Verification
Some rules are checked by assertions on every cycle:
- a step can only begin from the halted state;
- a completion during a step re-halts the core;
- a halt holds until a start or step arrives;
- each reset or flush pulse traces back to a matching control write;
- every request is acknowledged one cycle later.

Other behaviour needs the bench's directed scenarios:
- the exact bit positions of the control and status words;
- the address-2 and address-0 read values;
- stop winning over start when both are written together;
- steps written while running being ignored;
- writes to non-control addresses having no effect.

// File: rtl/dbgc_pkg.sv
`timescale 1ns/1ps
package dbgc_pkg;

    localparam int CTRL_W     = 5;
    localparam int REG_ADDR_W = 2;

    // Control bit positions (host visible)
    localparam int CB_STOP  = 0;
    localparam int CB_RST   = 1;
    localparam int CB_ICLR  = 2;
    localparam int CB_STEP  = 3;
    localparam int CB_START = 4;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_CTRL   = 2'd0,
        RA_STATUS = 2'd1,
        RA_NIA    = 2'd2,
        RA_SPARE  = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic start;
        logic step;
        logic iclr;
        logic rst;
        logic stop;
    } cmd_t;

    typedef struct packed {
        logic terminated;
        logic stop_pending;
        logic stopped;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    function automatic cmd_t decode_ctrl(input logic [CTRL_W-1:0] bits);
        cmd_t c;
        c.stop  = bits[CB_STOP];
        c.rst   = bits[CB_RST];
        c.iclr  = bits[CB_ICLR];
        c.step  = bits[CB_STEP];
        c.start = bits[CB_START];
        return c;
    endfunction

    function automatic status_t build_status(input logic held, input logic busy,
                                             input logic term);
        status_t s;
        s.stopped      = held & ~busy;
        s.stop_pending = held & busy;
        s.terminated   = term;
        return s;
    endfunction

endpackage

// File: rtl/dbgc_cmd_decode.sv
`timescale 1ns/1ps
module dbgc_cmd_decode
    import dbgc_pkg::*;
(
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [CTRL_W-1:0]     host_wdata,
    output cmd_t                  cmd
);

    logic ctrl_wr;

    always_comb begin
        ctrl_wr = host_req && host_we && (host_addr == RA_CTRL);
        cmd     = '0;
        if (ctrl_wr) begin
            cmd = decode_ctrl(host_wdata);
        end
    end

endmodule

// File: rtl/dbgc_pulse_gen.sv
`timescale 1ns/1ps
module dbgc_pulse_gen #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] trig,
    output logic [N-1:0] pulse
);

    for (genvar i = 0; i < N; i++) begin : g_pulse
        always_ff @(posedge clk) begin
            if (rst) begin
                pulse[i] <= 1'b0;
            end else begin
                pulse[i] <= trig[i];
            end
        end
    end

endmodule

// File: rtl/dbgc_run_ctrl.sv
`timescale 1ns/1ps
module dbgc_run_ctrl
    import dbgc_pkg::*;
#(
    parameter bit RESET_HALTED = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  cmd_t cmd,
    input  logic instr_done,
    output logic core_stop
);

    logic halted;
    logic stepping;

    always_ff @(posedge clk) begin
        if (rst) begin
            halted   <= RESET_HALTED;
            stepping <= 1'b0;
        end else begin
            if (cmd.stop) begin
                halted <= 1'b1;
            end else if (cmd.start) begin
                halted <= 1'b0;
            end

            if (cmd.start && !cmd.stop) begin
                stepping <= 1'b0;
            end else if (cmd.step && halted && !stepping) begin
                stepping <= 1'b1;
            end else if (stepping && instr_done) begin
                stepping <= 1'b0;
            end
        end
    end

    assign core_stop = halted & ~stepping;

    AST_STEP_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
        $rose(stepping) |-> $past(halted)); // R6

    AST_STEP_REHALTS: assert property (@(posedge clk) disable iff (rst)
        (stepping && instr_done && !cmd.start) |=> core_stop); // R6

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (core_stop && !cmd.start && !cmd.step) |=> core_stop); // R2

    AST_START_RUNS: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !cmd.stop) |=> !core_stop); // R3

endmodule

// File: rtl/dbgc_readback.sv
`timescale 1ns/1ps
module dbgc_readback
    import dbgc_pkg::*;
#(
    parameter int NIA_W  = 64,
    parameter int DATA_W = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [NIA_W-1:0]      core_nia,
    input  status_t               status,
    output logic                  host_ack,
    output logic [DATA_W-1:0]     host_rdata
);

    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (!host_we) begin
            case (reg_addr_e'(host_addr))
                RA_STATUS: rd_mux[STATUS_W-1:0] = status;
                RA_NIA:    rd_mux[NIA_W-1:0]    = core_nia;
                default:   rd_mux               = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_ack   <= 1'b0;
            host_rdata <= '0;
        end else begin
            host_ack <= host_req;
            if (host_req) begin
                host_rdata <= rd_mux;
            end
        end
    end

    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        host_ack |-> $past(host_req)); // R8

    AST_REQ_ACKED: assert property (@(posedge clk) disable iff (rst)
        host_req |=> host_ack); // R8

endmodule

// File: rtl/dbg_core_ctrl.sv
`timescale 1ns/1ps
module dbg_core_ctrl
    import dbgc_pkg::*;
#(
    parameter int NIA_W        = 64,
    parameter int DATA_W       = 64,
    parameter bit RESET_HALTED = 1'b0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  host_req,
    input  logic                  host_we,
    input  logic [REG_ADDR_W-1:0] host_addr,
    input  logic [CTRL_W-1:0]     host_wdata,
    output logic                  host_ack,
    output logic [DATA_W-1:0]     host_rdata,
    input  logic [NIA_W-1:0]      core_nia,
    input  logic                  core_busy,
    input  logic                  core_terminated,
    input  logic                  core_instr_done,
    output logic                  core_stop,
    output logic                  core_rst,
    output logic                  icache_flush
);

    localparam int PULSE_N = 2;

    cmd_t               cmd;
    status_t            status;
    logic [PULSE_N-1:0] pulse_trig;
    logic [PULSE_N-1:0] pulse_out;

    dbgc_cmd_decode u_decode (
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cmd        (cmd)
    );

    dbgc_run_ctrl #(
        .RESET_HALTED (RESET_HALTED)
    ) u_run (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .instr_done (core_instr_done),
        .core_stop  (core_stop)
    );

    assign pulse_trig = {cmd.iclr, cmd.rst};

    dbgc_pulse_gen #(
        .N (PULSE_N)
    ) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .trig  (pulse_trig),
        .pulse (pulse_out)
    );

    assign core_rst     = pulse_out[0];
    assign icache_flush = pulse_out[1];

    assign status = build_status(core_stop, core_busy, core_terminated);

    dbgc_readback #(
        .NIA_W  (NIA_W),
        .DATA_W (DATA_W)
    ) u_rb (
        .clk        (clk),
        .rst        (rst),
        .host_req   (host_req),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .core_nia   (core_nia),
        .status     (status),
        .host_ack   (host_ack),
        .host_rdata (host_rdata)
    );

    AST_RST_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> $past(host_req && host_we && host_addr == RA_CTRL
                           && host_wdata[CB_RST])); // R4

    AST_FLUSH_PULSE_SRC: assert property (@(posedge clk) disable iff (rst)
        icache_flush |-> $past(host_req && host_we && host_addr == RA_CTRL
                               && host_wdata[CB_ICLR])); // R5

endmodule

// File: tb/dbg_core_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_core_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_req, host_we;
    logic [1:0]  host_addr;
    logic [4:0]  host_wdata;
    logic        host_ack;
    logic [63:0] host_rdata;
    logic [63:0] core_nia;
    logic        core_busy, core_terminated, core_instr_done;
    logic        core_stop, core_rst, icache_flush;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    logic        rd_ack;
    logic [63:0] rd_val;

    always #2.5 clk = ~clk;

    dbg_core_ctrl u_dbg_core_ctrl (
        .clk(clk), .rst(rst),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
        .core_nia(core_nia), .core_busy(core_busy),
        .core_terminated(core_terminated), .core_instr_done(core_instr_done),
        .core_stop(core_stop), .core_rst(core_rst), .icache_flush(icache_flush)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // write: returns just after the edge where the write took effect
    task automatic do_write(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        host_req = 1; host_we = 1; host_addr = a; host_wdata = d;
        @(posedge clk); #1;
        host_req = 0; host_we = 0; host_wdata = '0;
    endtask

    task automatic do_read(input logic [1:0] a);
        @(negedge clk);
        host_req = 1; host_we = 0; host_addr = a;
        @(posedge clk); #1;
        rd_ack = host_ack; rd_val = host_rdata;
        host_req = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        core_instr_done = 1;
        @(posedge clk); #1;
        core_instr_done = 0;
    endtask

    task automatic t_reset();
        chk("R1 core_stop", core_stop, 0);
        chk("R1 core_rst", core_rst, 0);
        chk("R1 icache_flush", icache_flush, 0);
        chk("R1 host_ack", host_ack, 0);
    endtask

    task automatic t_stop_start();
        do_write(2'd0, 5'b00001);
        chk("R2 stop raises core_stop", core_stop, 1);
        idle(3);
        chk("R2 halt is sticky", core_stop, 1);
        core_busy = 0;
        do_read(2'd1);
        chk("R8 status stopped", rd_val, 64'h1);
        chk("R8 ack one cycle after read", rd_ack, 1);
        idle(1);
        chk("R8 ack drops", host_ack, 0);
        core_busy = 1;
        do_read(2'd1);
        chk("R8 status stop pending", rd_val, 64'h2);
        core_busy = 0;
        do_write(2'd0, 5'b10000);
        chk("R3 start lowers core_stop", core_stop, 0);
        do_write(2'd0, 5'b10001);
        chk("R3 stop wins over start", core_stop, 1);
        do_write(2'd0, 5'b10000);
        chk("R3 start after tie", core_stop, 0);
    endtask

    task automatic t_pulses();
        do_write(2'd0, 5'b00010);
        chk("R4 core_rst pulse", core_rst, 1);
        chk("R4 no flush on reset cmd", icache_flush, 0);
        idle(1);
        chk("R4 core_rst single cycle", core_rst, 0);
        do_write(2'd0, 5'b00100);
        chk("R5 flush pulse", icache_flush, 1);
        chk("R5 no core_rst on flush cmd", core_rst, 0);
        idle(1);
        chk("R5 flush single cycle", icache_flush, 0);
        do_write(2'd0, 5'b00001);
        do_write(2'd0, 5'b00010);
        chk("R4 reset keeps halt", core_stop, 1);
        do_write(2'd0, 5'b10000);
    endtask

    task automatic t_step();
        do_write(2'd0, 5'b00001);
        do_write(2'd0, 5'b01000);
        chk("R6 step releases core", core_stop, 0);
        idle(2);
        chk("R6 released until completion", core_stop, 0);
        done_pulse();
        chk("R6 re-halt after completion", core_stop, 1);
        done_pulse();
        chk("R7 completion while halted ignored", core_stop, 1);
        do_write(2'd0, 5'b10000);
        chk("R3 start after step", core_stop, 0);
    endtask

    task automatic t_step_running();
        do_write(2'd0, 5'b01000);
        chk("R7 step while running no stop", core_stop, 0);
        done_pulse();
        do_write(2'd0, 5'b00001);
        chk("R7 stop after ignored step halts", core_stop, 1);
        do_write(2'd0, 5'b10000);
    endtask

    task automatic t_reads();
        core_nia = 64'hDEAD_BEEF_0123_4568;
        do_read(2'd2);
        chk("R9 nia readback", rd_val, 64'hDEAD_BEEF_0123_4568);
        chk("R8 ack on nia read", rd_ack, 1);
        do_read(2'd0);
        chk("R9 addr0 reads zero", rd_val, 0);
        do_read(2'd3);
        chk("R9 addr3 reads zero", rd_val, 0);
        core_terminated = 1;
        do_read(2'd1);
        chk("R8 terminated bit", rd_val, 64'h4);
        core_terminated = 0;
    endtask

    task automatic t_ignored();
        do_write(2'd1, 5'b00111);
        chk("R10 stop via addr1 ignored", core_stop, 0);
        chk("R10 reset via addr1 ignored", core_rst, 0);
        chk("R10 flush via addr1 ignored", icache_flush, 0);
        do_write(2'd2, 5'b00001);
        chk("R10 stop via addr2 ignored", core_stop, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst = 1; host_req = 0; host_we = 0; host_addr = 0; host_wdata = 0;
        core_nia = 0; core_busy = 0; core_terminated = 0; core_instr_done = 0;
        rd_ack = 0; rd_val = 0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst = 0;
        @(posedge clk); #1;
        t_reset();
        t_stop_start();
        t_pulses();
        t_step();
        t_step_running();
        t_reads();
        t_ignored();
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule